// File: doc/BRIEF.md
# Front-Panel Switch Memory Loader

This block lets an operator hand-enter a program into RAM with eight data switches and a single LOAD push-button, and then launches it. Every entry is one deliberate press-and-release of LOAD. The first three entries form a header: the upper byte of the load address, then its lower byte, then the number of program bytes that follow. Each later entry stores the switch byte at the running address and steps that address up by one. When the last byte has been stored and LOAD released, the block emits a one-cycle start pulse with the header address beside it, so that a processor can jump there.

Both the switches and the button pass through synchronizer flops. The button then goes through a counter-based filter that accepts a new level only once it has been steady for `DEB_CYCLES` clocks, so contact bounce never counts as an entry. The control is one state machine with nine named states. HI_PRESS waits for the address-high press and goes to HI_RELEASE. HI_RELEASE waits for release and goes to LO_PRESS. LO_PRESS and LO_RELEASE do the same for the address-low byte, and CNT_PRESS and CNT_RELEASE for the count. On release, CNT_RELEASE goes to LAUNCH if the count is zero and to DATA_PRESS otherwise. DATA_PRESS writes one byte and goes to DATA_RELEASE. On release, DATA_RELEASE goes to LAUNCH if no bytes remain and back to DATA_PRESS otherwise. LAUNCH lasts one cycle and returns to HI_PRESS.

Top module: `panel_loader`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the loader in HI_PRESS, clears the remaining count, and holds `ram_we` and `start` low. A header that was partly entered before reset is discarded.
- R2: The filtered LOAD level changes only after the synchronized button has held the new level for `DEB_CYCLES` consecutive clocks. A pulse or gap shorter than that produces no entry.
- R3: Each entry is taken on a filtered press. No further entry is taken until a filtered release has been seen, so holding LOAD down yields exactly one entry.
- R4: The first entry after reset or launch sets load-address bits 15:8. The second entry sets bits 7:0.
- R5: The third entry sets the number of program bytes that follow (0 to 255).
- R6: Each data entry drives `ram_we` high for one cycle, with `ram_addr` equal to the current address and `ram_wdata` equal to the switch byte. The current address then increments by one and wraps from 0xFFFF to 0x0000.
- R7: After the final data entry is released, `start` is high for exactly one cycle and `start_addr` carries the header address. The loader then waits for a new address-high entry.
- R8: A count of zero launches right after the count entry is released, with no RAM write. Header entries never assert `ram_we`.
- R9: The byte written is the switch value at the moment of the filtered press. Changing the switches while LOAD stays held does not affect the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_data | input | 8 | Front-panel data switches |
| load_btn | input | 1 | Raw LOAD push-button, high when pressed |
| ram_addr | output | 16 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable, one cycle per stored byte |
| start | output | 1 | One-cycle launch pulse |
| start_addr | output | 16 | Address to launch at, valid with `start` |

## Verification
The loader is driven with a plain three-byte load, a zero-count header, and a load that straddles 0xFFFF. These separate the correct byte order, launching with no writes, and address wraparound. Short bounce pulses on LOAD, both before a header press and between data presses, show whether the filter rejects glitches rather than counting them as entries. Changing the switches while LOAD is held shows whether the byte is sampled at the press rather than later. A reset in the middle of a header shows whether partial entries are thrown away.

// File: rtl/pld_pkg.sv
package pld_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W;

    typedef enum logic [3:0] {
        HI_PRESS,
        HI_RELEASE,
        LO_PRESS,
        LO_RELEASE,
        CNT_PRESS,
        CNT_RELEASE,
        DATA_PRESS,
        DATA_RELEASE,
        LAUNCH
    } ld_state_t;

endpackage

// File: rtl/pld_sync.sv
module pld_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= '0;
                    else     chain[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= '0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/pld_debounce.sv
module pld_debounce #(
    parameter int DEB_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_in,
    output logic btn_level
);

    localparam int CNT_W = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

    logic [CNT_W-1:0] stable_cnt;
    logic             level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q    <= 1'b0;
            stable_cnt <= '0;
        end else if (btn_in == level_q) begin
            stable_cnt <= '0;
        end else if (stable_cnt == CNT_LAST) begin
            level_q    <= btn_in;
            stable_cnt <= '0;
        end else begin
            stable_cnt <= stable_cnt + 1'b1;
        end
    end

    assign btn_level = level_q;

    AST_DB_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        (level_q != $past(level_q)) |-> ($past(btn_in) == level_q)); // R2

endmodule

// File: rtl/pld_fsm.sv
module pld_fsm
    import pld_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] sw_byte,
    input  logic              btn_level,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [BYTE_W-1:0] ram_wdata,
    output logic              ram_we,
    output logic              start,
    output logic [ADDR_W-1:0] start_addr
);

    ld_state_t         state, state_nx;
    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W-1:0] cur_addr;
    logic [BYTE_W-1:0] remain;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= HI_PRESS;
        else     state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            HI_PRESS:     if (btn_level)  state_nx = HI_RELEASE;
            HI_RELEASE:   if (!btn_level) state_nx = LO_PRESS;
            LO_PRESS:     if (btn_level)  state_nx = LO_RELEASE;
            LO_RELEASE:   if (!btn_level) state_nx = CNT_PRESS;
            CNT_PRESS:    if (btn_level)  state_nx = CNT_RELEASE;
            CNT_RELEASE:  if (!btn_level) state_nx = (remain == '0) ? LAUNCH : DATA_PRESS;
            DATA_PRESS:   if (btn_level)  state_nx = DATA_RELEASE;
            DATA_RELEASE: if (!btn_level) state_nx = (remain == '0) ? LAUNCH : DATA_PRESS;
            LAUNCH:                       state_nx = HI_PRESS;
            default:                      state_nx = HI_PRESS;
        endcase
    end

    // header and address datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            cur_addr  <= '0;
            remain    <= '0;
        end else if (btn_level) begin
            unique case (state)
                HI_PRESS: base_addr[ADDR_W-1:BYTE_W] <= sw_byte;
                LO_PRESS: begin
                    base_addr[BYTE_W-1:0] <= sw_byte;
                    cur_addr              <= {base_addr[ADDR_W-1:BYTE_W], sw_byte};
                end
                CNT_PRESS: remain <= sw_byte;
                DATA_PRESS: begin
                    cur_addr <= cur_addr + 1'b1;
                    remain   <= remain - 1'b1;
                end
                default: ;
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            ram_we     <= 1'b0;
            ram_addr   <= '0;
            ram_wdata  <= '0;
            start      <= 1'b0;
            start_addr <= '0;
        end else begin
            ram_we <= (state == DATA_PRESS) && btn_level;
            start  <= (state == LAUNCH);
            if ((state == DATA_PRESS) && btn_level) begin
                ram_addr  <= cur_addr;
                ram_wdata <= sw_byte;
            end
            if (state == LAUNCH) start_addr <= base_addr;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (state == HI_PRESS && remain == '0 && !ram_we && !start)); // R1
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ram_we |=> !ram_we); // R3
    AST_WE_FROM_DATA: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> ($past(state) == DATA_PRESS)); // R8
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (state == DATA_RELEASE && $past(state) == DATA_PRESS)
            |-> (cur_addr == $past(cur_addr) + 1'b1)); // R6
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        start |=> !start); // R7
    AST_START_ADDR: assert property (@(posedge clk) disable iff (rst)
        start |-> (start_addr == base_addr && state == HI_PRESS)); // R7

endmodule

// File: rtl/panel_loader.sv
module panel_loader
    import pld_pkg::*;
#(
    parameter int DEB_CYCLES  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  sw_data,
    input  logic        load_btn,
    output logic [15:0] ram_addr,
    output logic [7:0]  ram_wdata,
    output logic        ram_we,
    output logic        start,
    output logic [15:0] start_addr
);

    logic [BYTE_W-1:0] sw_sync;
    logic              btn_sync;
    logic              btn_level;

    pld_sync #(.WIDTH(BYTE_W), .STAGES(SYNC_STAGES)) u_sw_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (sw_data),
        .dout (sw_sync)
    );

    pld_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_btn_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (load_btn),
        .dout (btn_sync)
    );

    pld_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_debounce (
        .clk       (clk),
        .rst       (rst),
        .btn_in    (btn_sync),
        .btn_level (btn_level)
    );

    pld_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .sw_byte    (sw_sync),
        .btn_level  (btn_level),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .ram_we     (ram_we),
        .start      (start),
        .start_addr (start_addr)
    );

endmodule

// File: tb/panel_loader_bench.sv
`timescale 1ns/1ps
module panel_loader_bench;

    localparam int DEB  = 4;
    localparam int HOLD = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  sw_data = 8'h00;
    logic        load_btn = 1'b0;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        ram_we;
    logic        start;
    logic [15:0] start_addr;

    int checks = 0;
    int errors = 0;

    logic [15:0] wr_addr [16];
    logic [7:0]  wr_data [16];
    int          n_wr = 0;
    int          n_st = 0;
    logic [15:0] st_addr = '0;
    int          dbl_st = 0;
    logic        prev_st = 1'b0;

    always #4 clk = ~clk;

    panel_loader #(.DEB_CYCLES(DEB), .SYNC_STAGES(2)) u_panel_loader (
        .clk        (clk),
        .rst        (rst),
        .sw_data    (sw_data),
        .load_btn   (load_btn),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .ram_we     (ram_we),
        .start      (start),
        .start_addr (start_addr)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (ram_we) begin
                if (n_wr < 16) begin
                    wr_addr[n_wr] = ram_addr;
                    wr_data[n_wr] = ram_wdata;
                end
                n_wr++;
            end
            if (start) begin
                n_st++;
                st_addr = start_addr;
                if (prev_st) dbl_st++;
            end
        end
        prev_st = start;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        n_wr = 0; n_st = 0; dbl_st = 0; st_addr = '0;
    endtask

    task automatic press(input logic [7:0] v);
        @(posedge clk); sw_data <= v;
        repeat (6) @(posedge clk);
        load_btn <= 1'b1;
        repeat (HOLD) @(posedge clk);
        load_btn <= 1'b0;
        repeat (HOLD) @(posedge clk);
    endtask

    task automatic glitch(input int len);
        @(posedge clk); load_btn <= 1'b1;
        repeat (len) @(posedge clk);
        load_btn <= 1'b0;
        repeat (HOLD) @(posedge clk);
    endtask

    task automatic do_reset();
        @(posedge clk); rst <= 1'b1;
        repeat (3) @(posedge clk);
        rst <= 1'b0;
        repeat (2) @(posedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        chk(ram_we == 1'b0, "R1 ram_we after reset", ram_we, 0);
        chk(start == 1'b0, "R1 start after reset", start, 0);
    endtask

    task automatic t_basic();
        clear_log();
        press(8'h12); press(8'h34); press(8'h03);
        chk(n_wr == 0, "R8 no write during header", n_wr, 0);
        press(8'hA1); press(8'hB2);
        chk(n_st == 0, "R7 no start before last byte", n_st, 0);
        press(8'hC3);
        chk(n_wr == 3, "R6 write count", n_wr, 3);
        chk(wr_addr[0] == 16'h1234, "R4 first write addr", wr_addr[0], 16'h1234);
        chk(wr_addr[1] == 16'h1235, "R6 second write addr", wr_addr[1], 16'h1235);
        chk(wr_addr[2] == 16'h1236, "R6 third write addr", wr_addr[2], 16'h1236);
        chk(wr_data[0] == 8'hA1 && wr_data[1] == 8'hB2 && wr_data[2] == 8'hC3,
            "R6 write data", {wr_data[0], wr_data[1], wr_data[2]}, 24'hA1B2C3);
        chk(n_st == 1, "R7 one start pulse", n_st, 1);
        chk(dbl_st == 0, "R7 start single cycle", dbl_st, 0);
        chk(st_addr == 16'h1234, "R7 start address", st_addr, 16'h1234);
    endtask

    task automatic t_zero_count();
        clear_log();
        press(8'h56); press(8'h78); press(8'h00);
        chk(n_wr == 0, "R8 zero count writes", n_wr, 0);
        chk(n_st == 1, "R8 zero count start", n_st, 1);
        chk(st_addr == 16'h5678, "R5 zero count address", st_addr, 16'h5678);
    endtask

    task automatic t_wrap();
        clear_log();
        press(8'hFF); press(8'hFE); press(8'h03);
        press(8'h11); press(8'h22); press(8'h33);
        chk(n_wr == 3, "R5 wrap write count", n_wr, 3);
        chk(wr_addr[1] == 16'hFFFF, "R6 addr FFFF", wr_addr[1], 16'hFFFF);
        chk(wr_addr[2] == 16'h0000, "R6 addr wraps", wr_addr[2], 0);
        chk(st_addr == 16'hFFFE, "R7 wrap start address", st_addr, 16'hFFFE);
    endtask

    task automatic t_held_change();
        clear_log();
        press(8'h20); press(8'h00); press(8'h01);
        @(posedge clk); sw_data <= 8'h5A;
        repeat (6) @(posedge clk);
        load_btn <= 1'b1;
        repeat (15) @(posedge clk);
        sw_data <= 8'hC6;
        repeat (HOLD) @(posedge clk);
        chk(n_wr == 1, "R3 held button one entry", n_wr, 1);
        load_btn <= 1'b0;
        repeat (HOLD) @(posedge clk);
        chk(wr_data[0] == 8'h5A, "R9 byte sampled at press", wr_data[0], 8'h5A);
        chk(n_st == 1, "R7 held change start", n_st, 1);
    endtask

    task automatic t_bounce();
        clear_log();
        glitch(DEB - 1);
        press(8'h40); press(8'h10); press(8'h02);
        press(8'h01);
        glitch(DEB - 1);
        glitch(2);
        chk(n_wr == 1, "R2 bounce gives no write", n_wr, 1);
        chk(n_st == 0, "R2 bounce gives no start", n_st, 0);
        press(8'h02);
        chk(wr_addr[0] == 16'h4010, "R2 bounce before header ignored", wr_addr[0], 16'h4010);
        chk(n_wr == 2 && n_st == 1, "R2 bounce sequence end", n_wr * 16 + n_st, 33);
    endtask

    task automatic t_reset_mid();
        clear_log();
        press(8'hAB);
        do_reset();
        press(8'h00); press(8'h40); press(8'h01);
        press(8'h77);
        chk(n_wr == 1 && wr_addr[0] == 16'h0040, "R1 partial header dropped",
            wr_addr[0], 16'h0040);
        chk(st_addr == 16'h0040, "R1 start after reset", st_addr, 16'h0040);
    endtask

    initial begin
        t_reset_state();
        t_basic();
        t_zero_count();
        t_wrap();
        t_held_change();
        t_bounce();
        t_reset_mid();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule